// File: doc/BRIEF.md
# Set/Clear Register GPIO Controller

This block is a register-mapped general-purpose I/O controller with four pin groups, reached over a simple synchronous bus (byte address, write enable, 32-bit write data, 32-bit read data). Groups 0, 1 and 2 are plain bidirectional groups of 8, 24 and 13 pins. Each group has an output level register and a direction register. Neither register is ever written directly. Software writes a mask to a set address, which raises the selected bits, or to a clear address, which lowers them. Because of this, two agents can change different pins without a read-modify-write race.

Group 3 combines three kinds of pin in shared 32-bit words with an irregular bit layout: six bidirectional pins, 22 dedicated inputs and 24 dedicated outputs. The direction bits of its bidirectional pins live in the upper part of the group 2 direction register. Group 2 also has a small multiplexer selection register with its own set, clear and state addresses. Every pin input passes through a two-flop synchronizer before software can read it. Read data is combinational from the address, so it is valid in the same cycle the address is presented.

Top module: `gpio_setclr_ctrl`

## Requirements
- R1: A write to a set address forces to 1 every implemented bit written as 1. Bits written as 0 keep their value.
- R2: A write to a clear address forces to 0 every bit written as 1. Bits written as 0 keep their value.
- R3: After reset every level, direction and mux register is zero, so all output and output-enable pins are low.
- R4: A direction bit of 1 drives the matching output-enable pin high (pin is an output). A direction bit of 0 makes the pin an input.
- R5: Group 0 has 8 pins, group 1 has 24 and group 2 has 13, with pin n at bit n. Group 0 addresses: input 0x40, level set/clear/state 0x44/0x48/0x4C, direction set/clear/state 0x50/0x54/0x58. Group 1 uses the same layout at 0x60 to 0x78. Group 2 addresses: direction 0x10/0x14/0x18, input 0x1C, level set/clear 0x20/0x24.
- R6: Group 3 bidirectional pin n (n = 0..5) drives from bit n+25 of the group 3 level register (set 0x04, clear 0x08, state 0x0C). Its output enable comes from bit n+25 of the group 2 direction register.
- R7: The group 3 input word (0x00) holds: bidirectional pins 0..4 at bits 10..14 and pin 5 at bit 24; dedicated inputs 0..9 at bits 0..9; dedicated inputs 10..18 at bits 15..23; dedicated inputs 19..21 at bits 25..27. All other bits read 0.
- R8: Group 3 dedicated output n (n = 0..23) is bit n of the group 3 level register.
- R9: Reading a set or clear address returns the current register value. Bits with no pin behind them always read 0 (for example 0x7EFF_FFFF is the most the group 3 level register can hold). Unused addresses read 0.
- R10: A change on any input pin appears in its input word after the second rising clock edge and not after the first.
- R11: The group 2 mux register (MUX_W bits, default 3) has set 0x28, clear 0x2C and state 0x30, and drives the mux selection output.
- R12: Writes to input-state addresses or unused addresses change no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data (mask for set/clear) |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| g0_pin_in | input | P0_W | Group 0 pin inputs |
| g0_pin_out | output | P0_W | Group 0 output levels |
| g0_pin_oe | output | P0_W | Group 0 output enables |
| g1_pin_in | input | P1_W | Group 1 pin inputs |
| g1_pin_out | output | P1_W | Group 1 output levels |
| g1_pin_oe | output | P1_W | Group 1 output enables |
| g2_pin_in | input | P2_W | Group 2 pin inputs |
| g2_pin_out | output | P2_W | Group 2 output levels |
| g2_pin_oe | output | P2_W | Group 2 output enables |
| g2_mux_sel | output | MUX_W | Group 2 mux selection |
| g3_bidi_in | input | 6 | Group 3 bidirectional pin inputs |
| g3_bidi_out | output | 6 | Group 3 bidirectional output levels |
| g3_bidi_oe | output | 6 | Group 3 bidirectional output enables |
| g3_din | input | 22 | Group 3 dedicated inputs |
| g3_dout | output | 24 | Group 3 dedicated outputs |

## Verification
A corrupted level or direction register shows on the pin outputs one cycle after the write that caused it. It also shows in the readback of the matching set, clear or state address in that same cycle. A wrong bit map for group 3 shows as a pin moving when a different bit is written, or as an input appearing at the wrong read bit. Both are visible right away when single-bit patterns are used. A missing or doubled synchronizer stage shows as input data appearing one edge too early or too late, so the bench samples the input words after exactly one edge and again after two.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

    // Address map (byte offsets); software decodes these, so they are fixed
    localparam logic [7:0] A_G3_IN   = 8'h00;
    localparam logic [7:0] A_G3_LSET = 8'h04;
    localparam logic [7:0] A_G3_LCLR = 8'h08;
    localparam logic [7:0] A_G3_LST  = 8'h0C;
    localparam logic [7:0] A_G2_DSET = 8'h10;
    localparam logic [7:0] A_G2_DCLR = 8'h14;
    localparam logic [7:0] A_G2_DST  = 8'h18;
    localparam logic [7:0] A_G2_IN   = 8'h1C;
    localparam logic [7:0] A_G2_LSET = 8'h20;
    localparam logic [7:0] A_G2_LCLR = 8'h24;
    localparam logic [7:0] A_G2_MSET = 8'h28;
    localparam logic [7:0] A_G2_MCLR = 8'h2C;
    localparam logic [7:0] A_G2_MST  = 8'h30;
    localparam logic [7:0] A_G0_IN   = 8'h40;
    localparam logic [7:0] A_G0_LSET = 8'h44;
    localparam logic [7:0] A_G0_LCLR = 8'h48;
    localparam logic [7:0] A_G0_LST  = 8'h4C;
    localparam logic [7:0] A_G0_DSET = 8'h50;
    localparam logic [7:0] A_G0_DCLR = 8'h54;
    localparam logic [7:0] A_G0_DST  = 8'h58;
    localparam logic [7:0] A_G1_IN   = 8'h60;
    localparam logic [7:0] A_G1_LSET = 8'h64;
    localparam logic [7:0] A_G1_LCLR = 8'h68;
    localparam logic [7:0] A_G1_LST  = 8'h6C;
    localparam logic [7:0] A_G1_DSET = 8'h70;
    localparam logic [7:0] A_G1_DCLR = 8'h74;
    localparam logic [7:0] A_G1_DST  = 8'h78;

    // Group 3 fixed layout
    localparam int G3_BIDI_W   = 6;
    localparam int G3_DIN_W    = 22;
    localparam int G3_DOUT_W   = 24;
    localparam int G3_BIDI_LSB = 25;

    // All software-visible registers, each in its 32-bit bus format
    typedef struct packed {
        logic [31:0] g0_lvl;
        logic [31:0] g0_dir;
        logic [31:0] g1_lvl;
        logic [31:0] g1_dir;
        logic [31:0] g2_lvl;
        logic [31:0] g2_dir;
        logic [31:0] g2_mux;
        logic [31:0] g3_lvl;
    } gpio_regs_t;

    // Next value of one set/clear register pair
    function automatic logic [31:0] sc_next(
        input logic [31:0] cur,
        input logic        we,
        input logic [7:0]  addr,
        input logic [7:0]  set_a,
        input logic [7:0]  clr_a,
        input logic [31:0] wd,
        input logic [31:0] mask
    );
        logic [31:0] r;
        r = cur;
        if (we && addr == set_a)      r = cur | (wd & mask);
        else if (we && addr == clr_a) r = cur & ~(wd & mask);
        return r;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/gpio_g3_pack.sv
module gpio_g3_pack
    import gpio_sc_pkg::*;
(
    input  logic [G3_DIN_W-1:0]  din,
    input  logic [G3_BIDI_W-1:0] bidi,
    output logic [31:0]          word
);
    always_comb begin
        word = '0;
        // dedicated inputs fill the gaps around the bidirectional bits
        for (int i = 0; i < 10; i++)  word[i]     = din[i];
        for (int i = 10; i < 19; i++) word[i + 5] = din[i];
        for (int i = 19; i < 22; i++) word[i + 6] = din[i];
        // bidirectional pins 0..4 sit at 10..14, pin 5 at 24
        for (int n = 0; n < 5; n++)   word[10 + n] = bidi[n];
        word[24] = bidi[5];
    end
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
    import gpio_sc_pkg::*;
(
    input  logic [7:0]  addr,
    input  gpio_regs_t  regs,
    input  logic [31:0] g0_in_w,
    input  logic [31:0] g1_in_w,
    input  logic [31:0] g2_in_w,
    input  logic [31:0] g3_in_w,
    output logic [31:0] rdata
);
    always_comb begin
        case (addr)
            A_G3_IN:                          rdata = g3_in_w;
            A_G3_LSET, A_G3_LCLR, A_G3_LST:   rdata = regs.g3_lvl;
            A_G2_DSET, A_G2_DCLR, A_G2_DST:   rdata = regs.g2_dir;
            A_G2_IN:                          rdata = g2_in_w;
            A_G2_LSET, A_G2_LCLR:             rdata = regs.g2_lvl;
            A_G2_MSET, A_G2_MCLR, A_G2_MST:   rdata = regs.g2_mux;
            A_G0_IN:                          rdata = g0_in_w;
            A_G0_LSET, A_G0_LCLR, A_G0_LST:   rdata = regs.g0_lvl;
            A_G0_DSET, A_G0_DCLR, A_G0_DST:   rdata = regs.g0_dir;
            A_G1_IN:                          rdata = g1_in_w;
            A_G1_LSET, A_G1_LCLR, A_G1_LST:   rdata = regs.g1_lvl;
            A_G1_DSET, A_G1_DCLR, A_G1_DST:   rdata = regs.g1_dir;
            default:                          rdata = '0; // R9 unused offsets
        endcase
    end
endmodule

// File: rtl/gpio_setclr_ctrl.sv
module gpio_setclr_ctrl
    import gpio_sc_pkg::*;
#(
    parameter int P0_W  = 8,
    parameter int P1_W  = 24,
    parameter int P2_W  = 13,
    parameter int MUX_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           bus_addr,
    input  logic                 bus_we,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [P0_W-1:0]      g0_pin_in,
    output logic [P0_W-1:0]      g0_pin_out,
    output logic [P0_W-1:0]      g0_pin_oe,
    input  logic [P1_W-1:0]      g1_pin_in,
    output logic [P1_W-1:0]      g1_pin_out,
    output logic [P1_W-1:0]      g1_pin_oe,
    input  logic [P2_W-1:0]      g2_pin_in,
    output logic [P2_W-1:0]      g2_pin_out,
    output logic [P2_W-1:0]      g2_pin_oe,
    output logic [MUX_W-1:0]     g2_mux_sel,
    input  logic [G3_BIDI_W-1:0] g3_bidi_in,
    output logic [G3_BIDI_W-1:0] g3_bidi_out,
    output logic [G3_BIDI_W-1:0] g3_bidi_oe,
    input  logic [G3_DIN_W-1:0]  g3_din,
    output logic [G3_DOUT_W-1:0] g3_dout
);
    // Implemented-bit masks; unimplemented bits never leave zero (R9)
    localparam logic [31:0] M_G0    = 32'((64'd1 << P0_W) - 64'd1);
    localparam logic [31:0] M_G1    = 32'((64'd1 << P1_W) - 64'd1);
    localparam logic [31:0] M_G2    = 32'((64'd1 << P2_W) - 64'd1);
    localparam logic [31:0] M_MUX   = 32'((64'd1 << MUX_W) - 64'd1);
    localparam logic [31:0] M_BIDI  = 32'(((64'd1 << G3_BIDI_W) - 64'd1) << G3_BIDI_LSB);
    localparam logic [31:0] M_DOUT  = 32'((64'd1 << G3_DOUT_W) - 64'd1);
    localparam logic [31:0] M_G2DIR = M_G2 | M_BIDI;
    localparam logic [31:0] M_G3LVL = M_DOUT | M_BIDI;
    localparam int SYNC_W = P0_W + P1_W + P2_W + G3_BIDI_W + G3_DIN_W;

    // ---------------- input synchronizers (R10) ----------------
    logic [SYNC_W-1:0]    sync_out;
    logic [P0_W-1:0]      g0_s;
    logic [P1_W-1:0]      g1_s;
    logic [P2_W-1:0]      g2_s;
    logic [G3_BIDI_W-1:0] g3b_s;
    logic [G3_DIN_W-1:0]  g3d_s;
    logic [31:0]          g3_in_w;

    gpio_sync #(.W(SYNC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({g3_din, g3_bidi_in, g2_pin_in, g1_pin_in, g0_pin_in}),
        .dout  (sync_out)
    );

    assign {g3d_s, g3b_s, g2_s, g1_s, g0_s} = sync_out;

    gpio_g3_pack u_pack (
        .din  (g3d_s),
        .bidi (g3b_s),
        .word (g3_in_w)
    );

    // ---------------- set/clear registers ----------------
    gpio_regs_t regs_d, regs_q;

    always_comb begin
        regs_d        = regs_q;
        regs_d.g0_lvl = sc_next(regs_q.g0_lvl, bus_we, bus_addr, A_G0_LSET, A_G0_LCLR, bus_wdata, M_G0);
        regs_d.g0_dir = sc_next(regs_q.g0_dir, bus_we, bus_addr, A_G0_DSET, A_G0_DCLR, bus_wdata, M_G0);
        regs_d.g1_lvl = sc_next(regs_q.g1_lvl, bus_we, bus_addr, A_G1_LSET, A_G1_LCLR, bus_wdata, M_G1);
        regs_d.g1_dir = sc_next(regs_q.g1_dir, bus_we, bus_addr, A_G1_DSET, A_G1_DCLR, bus_wdata, M_G1);
        regs_d.g2_lvl = sc_next(regs_q.g2_lvl, bus_we, bus_addr, A_G2_LSET, A_G2_LCLR, bus_wdata, M_G2);
        regs_d.g2_dir = sc_next(regs_q.g2_dir, bus_we, bus_addr, A_G2_DSET, A_G2_DCLR, bus_wdata, M_G2DIR);
        regs_d.g2_mux = sc_next(regs_q.g2_mux, bus_we, bus_addr, A_G2_MSET, A_G2_MCLR, bus_wdata, M_MUX);
        regs_d.g3_lvl = sc_next(regs_q.g3_lvl, bus_we, bus_addr, A_G3_LSET, A_G3_LCLR, bus_wdata, M_G3LVL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;   // R3
        else        regs_q <= regs_d;
    end

    // ---------------- pin outputs ----------------
    assign g0_pin_out  = regs_q.g0_lvl[P0_W-1:0];
    assign g0_pin_oe   = regs_q.g0_dir[P0_W-1:0];
    assign g1_pin_out  = regs_q.g1_lvl[P1_W-1:0];
    assign g1_pin_oe   = regs_q.g1_dir[P1_W-1:0];
    assign g2_pin_out  = regs_q.g2_lvl[P2_W-1:0];
    assign g2_pin_oe   = regs_q.g2_dir[P2_W-1:0];
    assign g2_mux_sel  = regs_q.g2_mux[MUX_W-1:0];
    assign g3_bidi_out = regs_q.g3_lvl[G3_BIDI_LSB +: G3_BIDI_W];  // R6
    assign g3_bidi_oe  = regs_q.g2_dir[G3_BIDI_LSB +: G3_BIDI_W];  // R6
    assign g3_dout     = regs_q.g3_lvl[G3_DOUT_W-1:0];             // R8

    // ---------------- read path ----------------
    gpio_rd_mux u_rd (
        .addr    (bus_addr),
        .regs    (regs_q),
        .g0_in_w (32'(g0_s)),
        .g1_in_w (32'(g1_s)),
        .g2_in_w (32'(g2_s)),
        .g3_in_w (g3_in_w),
        .rdata   (bus_rdata)
    );

    // ---------------- assertions ----------------
    a_r1_set_g0: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_G0_LSET) |=>
            ((g0_pin_out & $past(bus_wdata[P0_W-1:0])) == $past(bus_wdata[P0_W-1:0])) &&
            ((g0_pin_out & ~$past(bus_wdata[P0_W-1:0])) == ($past(g0_pin_out) & ~$past(bus_wdata[P0_W-1:0]))));

    a_r2_clr_g1_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_G1_DCLR) |=>
            ((g1_pin_oe & $past(bus_wdata[P1_W-1:0])) == '0) &&
            ((g1_pin_oe & ~$past(bus_wdata[P1_W-1:0])) == ($past(g1_pin_oe) & ~$past(bus_wdata[P1_W-1:0]))));

    a_r6_bidi_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && (bus_addr == A_G2_DSET || bus_addr == A_G2_DCLR)) |=> $stable(g3_bidi_oe));

    a_r8_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && (bus_addr == A_G3_LSET || bus_addr == A_G3_LCLR)) |=> $stable(g3_dout) && $stable(g3_bidi_out));

    a_r12_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == A_G0_IN || bus_addr == A_G3_IN || bus_addr == 8'h34)) |=>
            $stable(g0_pin_out) && $stable(g2_pin_oe) && $stable(g2_mux_sel) && $stable(g3_dout));

    a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 8'h34 || bus_addr == 8'h7C) |-> bus_rdata == 32'h0);
endmodule

// File: tb/tb_gpio_setclr_ctrl.sv
module tb_gpio_setclr_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  g0_pin_in = '0;
    logic [7:0]  g0_pin_out, g0_pin_oe;
    logic [23:0] g1_pin_in = '0;
    logic [23:0] g1_pin_out, g1_pin_oe;
    logic [12:0] g2_pin_in = '0;
    logic [12:0] g2_pin_out, g2_pin_oe;
    logic [2:0]  g2_mux_sel;
    logic [5:0]  g3_bidi_in = '0;
    logic [5:0]  g3_bidi_out, g3_bidi_oe;
    logic [21:0] g3_din = '0;
    logic [23:0] g3_dout;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    gpio_setclr_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .g0_pin_in(g0_pin_in), .g0_pin_out(g0_pin_out), .g0_pin_oe(g0_pin_oe),
        .g1_pin_in(g1_pin_in), .g1_pin_out(g1_pin_out), .g1_pin_oe(g1_pin_oe),
        .g2_pin_in(g2_pin_in), .g2_pin_out(g2_pin_out), .g2_pin_oe(g2_pin_oe),
        .g2_mux_sel(g2_mux_sel),
        .g3_bidi_in(g3_bidi_in), .g3_bidi_out(g3_bidi_out), .g3_bidi_oe(g3_bidi_oe),
        .g3_din(g3_din), .g3_dout(g3_dout)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
        end
    endtask

    // write: drive at a falling edge, captured at the next rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    // expected group 3 input word from the R7 layout
    function automatic logic [31:0] g3_word(input logic [21:0] d, input logic [5:0] b);
        logic [31:0] w = '0;
        for (int i = 0; i < 22; i++) begin
            if (i < 10)      w[i] = d[i];
            else if (i < 19) w[i + 5] = d[i];
            else             w[i + 6] = d[i];
        end
        for (int n = 0; n < 5; n++) w[10 + n] = b[n];
        w[24] = b[5];
        return w;
    endfunction

    task automatic t_reset;
        chk("R3 g0 out", 32'(g0_pin_out), 0);
        chk("R3 g0 oe", 32'(g0_pin_oe), 0);
        chk("R3 g1 oe", 32'(g1_pin_oe), 0);
        chk("R3 g2 mux", 32'(g2_mux_sel), 0);
        chk("R3 g3 bidi oe", 32'(g3_bidi_oe), 0);
        chk("R3 g3 dout", 32'(g3_dout), 0);
        rd_chk("R3 g3 level", 8'h0C, 0);
        rd_chk("R3 g2 dir", 8'h18, 0);
    endtask

    task automatic t_group0;
        wr(8'h44, 32'hA5);
        chk("R1 g0 set", 32'(g0_pin_out), 32'hA5);
        wr(8'h44, 32'h0F);
        chk("R1 g0 set keeps", 32'(g0_pin_out), 32'hAF);
        wr(8'h48, 32'h81);
        chk("R2 g0 clear", 32'(g0_pin_out), 32'h2E);
        rd_chk("R9 g0 read via clear addr", 8'h48, 32'h2E);
        rd_chk("R5 g0 level state", 8'h4C, 32'h2E);
        wr(8'h50, 32'hF0);
        chk("R4 g0 oe", 32'(g0_pin_oe), 32'hF0);
        chk("R4 g0 out untouched", 32'(g0_pin_out), 32'h2E);
        wr(8'h54, 32'h30);
        chk("R4 g0 oe clear", 32'(g0_pin_oe), 32'hC0);
        rd_chk("R5 g0 dir state", 8'h58, 32'hC0);
        wr(8'h44, 32'hFFFF_FFFF);
        rd_chk("R9 g0 unimplemented bits", 8'h44, 32'hFF);
        wr(8'h48, 32'hFFFF_FF00);
        chk("R2 g0 clear zero bits keep", 32'(g0_pin_out), 32'hFF);
    endtask

    task automatic t_group1;
        wr(8'h64, 32'h00FF_FF00);
        chk("R1 g1 set", 32'(g1_pin_out), 32'hFF_FF00);
        wr(8'h70, 32'hFFFF_FFFF);
        rd_chk("R5 g1 dir width", 8'h78, 32'h00FF_FFFF);
        wr(8'h74, 32'h0000_0F0F);
        chk("R2 g1 dir clear", 32'(g1_pin_oe), 32'hFF_F0F0);
        wr(8'h68, 32'h0012_3400);
        rd_chk("R5 g1 level state", 8'h6C, 32'h00ED_CB00);
    endtask

    task automatic t_group2;
        wr(8'h20, 32'h1FFF);
        chk("R1 g2 set", 32'(g2_pin_out), 32'h1FFF);
        wr(8'h24, 32'h1000);
        chk("R2 g2 clear", 32'(g2_pin_out), 32'h0FFF);
        rd_chk("R9 g2 level via clear", 8'h24, 32'h0FFF);
        wr(8'h10, 32'h1001);
        chk("R4 g2 oe", 32'(g2_pin_oe), 32'h1001);
        wr(8'h28, 32'h5);
        chk("R11 mux set", 32'(g2_mux_sel), 32'h5);
        wr(8'h2C, 32'h1);
        chk("R11 mux clear", 32'(g2_mux_sel), 32'h4);
        rd_chk("R11 mux state", 8'h30, 32'h4);
        wr(8'h28, 32'hFFFF_FFFF);
        rd_chk("R11 mux width", 8'h30, 32'h7);
    endtask

    task automatic t_group3_out;
        wr(8'h04, 32'h7E00_0003);
        chk("R6 bidi out", 32'(g3_bidi_out), 32'h3F);
        chk("R8 dout", 32'(g3_dout), 32'h3);
        wr(8'h08, 32'h2000_0000);
        chk("R6 bidi pin4 cleared", 32'(g3_bidi_out), 32'h2F);
        rd_chk("R6 level state", 8'h0C, 32'h5E00_0003);
        wr(8'h10, 32'h0400_0000);
        chk("R6 bidi oe from g2 dir", 32'(g3_bidi_oe), 32'h02);
        chk("R6 g2 oe untouched", 32'(g2_pin_oe), 32'h1001);
        rd_chk("R6 g2 dir state", 8'h18, 32'h0400_1001);
        wr(8'h04, 32'hFFFF_FFFF);
        rd_chk("R9 g3 level implemented bits", 8'h04, 32'h7EFF_FFFF);
        chk("R8 dout all", 32'(g3_dout), 32'hFF_FFFF);
        wr(8'h08, 32'h0080_0001);
        chk("R8 dout clear ends", 32'(g3_dout), 32'h7F_FFFE);
    endtask

    task automatic t_group3_in;
        logic [21:0] d_pat [3] = '{22'h000000, 22'h3FFFFF, 22'h2A5A5A};
        logic [5:0]  b_pat [3] = '{6'b100001, 6'b000000, 6'b011110};
        for (int k = 0; k < 3; k++) begin
            g3_din = d_pat[k]; g3_bidi_in = b_pat[k];
            @(negedge clk); @(negedge clk);
            rd_chk("R7 g3 input word", 8'h00, g3_word(d_pat[k], b_pat[k]));
        end
    endtask

    task automatic t_sync;
        g1_pin_in = 24'hABCDEF;
        g0_pin_in = 8'h5A;
        @(negedge clk);
        rd_chk("R10 g1 not after one edge", 8'h60, 32'h0);
        @(negedge clk);
        rd_chk("R10 g1 after two edges", 8'h60, 32'h00AB_CDEF);
        rd_chk("R10 g0 after two edges", 8'h40, 32'h5A);
        g2_pin_in = 13'h1ABC;
        @(negedge clk);
        rd_chk("R10 g2 not after one edge", 8'h1C, 32'h0);
        @(negedge clk);
        rd_chk("R10 g2 after two edges", 8'h1C, 32'h1ABC);
    endtask

    task automatic t_readonly;
        logic [31:0] l0, l3, d2;
        rd(8'h4C, l0); rd(8'h0C, l3); rd(8'h18, d2);
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h34, 32'hFFFF_FFFF);
        wr(8'h7C, 32'h0000_0000);
        wr(8'h1C, 32'hFFFF_FFFF);
        rd_chk("R12 g0 level kept", 8'h4C, l0);
        rd_chk("R12 g3 level kept", 8'h0C, l3);
        rd_chk("R12 g2 dir kept", 8'h18, d2);
        chk("R12 g0 pins kept", 32'(g0_pin_out), l0);
        rd_chk("R9 unused offset", 8'h34, 32'h0);
        rd_chk("R9 unused offset top", 8'h7C, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_group0();
        t_group1();
        t_group2();
        t_group3_out();
        t_group3_in();
        t_sync();
        t_readonly();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule